// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits behind a host bus slave that only ever delivers 32-bit dword writes. Some targets behind it are wider: 128-bit control registers and 64-bit memory words. Those targets must change in one step. The block gathers the dwords of such a target in a single collector buffer. The buffer remembers the aligned target address and which dword lanes already hold data. Once the target is complete, the block emits one wide commit that carries the aligned address, the full data and a size code. Any address that is not part of a wide target passes straight through as a single-dword commit.

Descriptor pointer registers are 128 bits wide but are treated differently so that software never has to lock around them. A write to the top dword (bits 127:96) of such a register always commits it. If the three lower lanes of that same register were not all collected first, bits 95:0 are committed as zero. A lower-dword write to one of these registers is discarded when the collector already holds another target, and the collector keeps its state. The descriptor registers repeat in every 8 KiB page. A plain dword write to the timer command register of page 0 empties the collector as a side effect.

Top module: `wide_write_collector`

## Requirements
- R1: After synchronous reset `cmt_valid` is 0 and the collector is empty, so a first descriptor top-dword write commits with bits 95:0 zero.
- R2: In page 0, offsets below `WIDE_END` (default 0x400) form normal 128-bit registers, with dword lane = address bits 3:2. No commit occurs until all four lanes of one register have been written, in any order. The fourth write produces one commit of `{lane3,lane2,lane1,lane0}` at the 16-byte-aligned address.
- R3: Addresses at or above `MEM_BASE` (default 0x80000) form 64-bit memory words, with lane = address bit 2. The commit happens once both lanes are present. It carries `{64'b0,lane1,lane0}` at the 8-byte-aligned address with size code 1.
- R4: A normal wide write to a different wide word than the one being collected restarts collection at the new word, and the old partial lanes are lost.
- R5: A write to lane 3 of a descriptor register (page offsets 0x830..0x83F and 0xA10..0xA1F) always commits, even when the collector held another target.
- R6: A descriptor commit carries the collected lanes 0..2 of that same register only if all three are present; otherwise bits 95:0 are zero.
- R7: A lower-lane descriptor write is dropped when the collector holds lanes of a different target. No commit is produced and that target can still complete with its original data.
- R8: The page index is address bits above bit 12. The descriptor decode uses only the in-page offset, and commit addresses keep the page bits.
- R9: A write to address 0x420 of page 0 clears the collector. The same write address in any other page does not clear it.
- R10: Every other address commits as a single dword with size code 0, data in bits 31:0, bits 127:32 zero, and the dword-aligned address.
- R11: The collector is empty after each wide or descriptor commit. `cmt_valid` is high only in the cycle after an accepted write.
- R12: Size codes are 0 = dword, 1 = 64-bit word, 2 = 128-bit register. A commit appears on the outputs one clock after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Dword write valid |
| wr_addr | input | ADDR_W | Byte address of the dword write (bits 1:0 ignored) |
| wr_data | input | 32 | Dword write data |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_addr | output | ADDR_W | Aligned address of the committed target |
| cmt_data | output | 128 | Committed data, zero above the target width |
| cmt_size | output | 2 | Size code: 0 dword, 1 64-bit, 2 128-bit |

## Verification
Two functions can land on the same clock edge: the single-dword pass-through commit of the page-0 timer write and the invalidation of the collector, and likewise a descriptor top-dword commit together with the discard of another target's partial lanes. The bench provokes the first by leaving two lanes of one 128-bit register in the collector, issuing the timer write, and then writing the two missing lanes; a commit at that point would expose a missed clear, while the timer write itself must still appear as a dword commit. The second case is judged the same way, by checking that the interrupted register stays silent after a foreign descriptor commit.

// File: rtl/wc_pkg.sv
`timescale 1ns/1ps
package wc_pkg;
    localparam int DW         = 32;
    localparam int LANES      = 4;
    localparam int WIDE_W     = DW * LANES;
    localparam int PAGE_SHIFT = 13;
    localparam int OFF_W      = PAGE_SHIFT;
    localparam int NUM_DESC   = 2;

    // in-page offsets of the descriptor pointer registers (16-byte aligned)
    localparam logic [NUM_DESC-1:0][OFF_W-1:0] DESC_OFF = {13'h0A10, 13'h0830};
    // timer command register, page 0 only has the collector side effect
    localparam logic [OFF_W-1:0] TIMER_OFF = 13'h0420;

    typedef enum logic [1:0] {
        ACC_SINGLE = 2'd0,
        ACC_WIDE   = 2'd1,
        ACC_MEM    = 2'd2,
        ACC_DESC   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_DWORD = 2'd0,
        SZ_QWORD = 2'd1,
        SZ_OWORD = 2'd2
    } cmt_size_e;

    typedef logic [DW-1:0]     dword_t;
    typedef logic [WIDE_W-1:0] wide_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    function automatic lane_mask_t lane_onehot(input logic [1:0] lane);
        lane_mask_t m;
        m = '0;
        m[lane] = 1'b1;
        return m;
    endfunction

    function automatic logic target_full(input acc_kind_e kind, input lane_mask_t m);
        if (kind == ACC_MEM) return &m[1:0];
        return &m;
    endfunction

    function automatic cmt_size_e kind_size(input acc_kind_e kind);
        case (kind)
            ACC_MEM:  return SZ_QWORD;
            ACC_WIDE: return SZ_OWORD;
            ACC_DESC: return SZ_OWORD;
            default:  return SZ_DWORD;
        endcase
    endfunction
endpackage

// File: rtl/wc_decode.sv
`timescale 1ns/1ps
module wc_decode
    import wc_pkg::*;
#(
    parameter int               ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] MEM_BASE = 20'h80000,
    parameter logic [OFF_W-1:0]  WIDE_END = 13'h0400
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [1:0]        lane,
    output logic              top,
    output logic              timer_hit,
    output logic [ADDR_W-1:0] base
);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  off;
    logic [PAGE_W-1:0] page;
    logic              in_mem;
    logic              page0;
    logic [NUM_DESC-1:0] desc_match;
    logic              unused_lsb;

    assign off        = addr[OFF_W-1:0];
    assign page       = addr[ADDR_W-1:OFF_W];
    assign in_mem     = (addr >= MEM_BASE);
    assign page0      = (page == '0);
    assign unused_lsb = ^addr[1:0];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_desc
        assign desc_match[g] = (off[OFF_W-1:4] == DESC_OFF[g][OFF_W-1:4]);
    end

    always_comb begin
        kind = ACC_SINGLE;
        lane = addr[3:2];
        base = {addr[ADDR_W-1:2], 2'b00};
        if (in_mem) begin
            kind = ACC_MEM;
            lane = {1'b0, addr[2]};
            base = {addr[ADDR_W-1:3], 3'b000};
        end else if (|desc_match) begin
            kind = ACC_DESC;
            base = {addr[ADDR_W-1:4], 4'b0000};
        end else if (page0 && (off < WIDE_END)) begin
            kind = ACC_WIDE;
            base = {addr[ADDR_W-1:4], 4'b0000};
        end
    end

    assign top       = (kind == ACC_DESC) && (addr[3:2] == 2'd3);
    assign timer_hit = !in_mem && page0 && (off[OFF_W-1:2] == TIMER_OFF[OFF_W-1:2]);
endmodule

// File: rtl/wc_collect.sv
`timescale 1ns/1ps
module wc_collect
    import wc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  acc_kind_e         kind,
    input  logic [1:0]        lane,
    input  logic              top,
    input  logic              timer_hit,
    input  logic [ADDR_W-1:0] base,
    input  dword_t            wdata,
    output logic              fire,
    output logic [ADDR_W-1:0] fire_addr,
    output wide_t             fire_data,
    output cmt_size_e         fire_size,
    output lane_mask_t        mask_q
);
    typedef logic [LANES-1:0][DW-1:0] lane_arr_t;

    logic [ADDR_W-1:0] tgt_q, tgt_n;
    lane_mask_t        mask_n, m_acc;
    lane_arr_t         lanes_q, lanes_n, l_acc;
    logic              busy, hit;

    assign busy = (mask_q != '0);
    assign hit  = busy && (tgt_q == base);

    always_comb begin
        m_acc       = (hit ? mask_q : '0) | lane_onehot(lane);
        l_acc       = hit ? lanes_q : '0;
        l_acc[lane] = wdata;
    end

    always_comb begin
        tgt_n     = tgt_q;
        mask_n    = mask_q;
        lanes_n   = lanes_q;
        fire      = 1'b0;
        fire_addr = base;
        fire_data = '0;
        fire_size = kind_size(kind);
        if (wr_en) begin
            unique case (kind)
                ACC_SINGLE: begin
                    fire      = 1'b1;
                    fire_data = {{(WIDE_W-DW){1'b0}}, wdata};
                    if (timer_hit) begin
                        tgt_n   = '0;
                        mask_n  = '0;
                        lanes_n = '0;
                    end
                end
                ACC_WIDE, ACC_MEM: begin
                    if (target_full(kind, m_acc)) begin
                        fire      = 1'b1;
                        fire_data = (kind == ACC_WIDE) ? wide_t'(l_acc)
                                  : {{(WIDE_W-2*DW){1'b0}}, l_acc[1], l_acc[0]};
                        tgt_n     = '0;
                        mask_n    = '0;
                        lanes_n   = '0;
                    end else begin
                        tgt_n   = base;
                        mask_n  = m_acc;
                        lanes_n = l_acc;
                    end
                end
                ACC_DESC: begin
                    if (top) begin
                        fire      = 1'b1;
                        fire_data = (hit && (&mask_q[2:0]))
                                  ? {wdata, lanes_q[2], lanes_q[1], lanes_q[0]}
                                  : {wdata, {(WIDE_W-DW){1'b0}}};
                        tgt_n     = '0;
                        mask_n    = '0;
                        lanes_n   = '0;
                    end else if (!busy || hit) begin
                        tgt_n   = base;
                        mask_n  = m_acc;
                        lanes_n = l_acc;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q   <= '0;
            mask_q  <= '0;
            lanes_q <= '0;
        end else begin
            tgt_q   <= tgt_n;
            mask_q  <= mask_n;
            lanes_q <= lanes_n;
        end
    end
endmodule

// File: rtl/wc_commit.sv
`timescale 1ns/1ps
module wc_commit
    import wc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] fire_addr,
    input  wide_t             fire_data,
    input  cmt_size_e         fire_size,
    output logic              valid_q,
    output logic [ADDR_W-1:0] addr_q,
    output wide_t             data_q,
    output cmt_size_e         size_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            size_q  <= SZ_DWORD;
        end else begin
            valid_q <= fire;
            if (fire) begin
                addr_q <= fire_addr;
                data_q <= fire_data;
                size_q <= fire_size;
            end
        end
    end
endmodule

// File: rtl/wide_write_collector.sv
`timescale 1ns/1ps
module wide_write_collector
    import wc_pkg::*;
#(
    parameter int               ADDR_W   = 20,
    parameter logic [ADDR_W-1:0] MEM_BASE = 20'h80000,
    parameter logic [OFF_W-1:0]  WIDE_END = 13'h0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              cmt_valid,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [WIDE_W-1:0] cmt_data,
    output logic [1:0]        cmt_size
);
    acc_kind_e         dec_kind;
    logic [1:0]        dec_lane;
    logic              dec_top, dec_timer;
    logic [ADDR_W-1:0] dec_base;
    logic              fire;
    logic [ADDR_W-1:0] fire_addr;
    wide_t             fire_data;
    cmt_size_e         fire_size, size_q;
    lane_mask_t        coll_mask;

    wc_decode #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .WIDE_END(WIDE_END)) u_dec (
        .addr      (wr_addr),
        .kind      (dec_kind),
        .lane      (dec_lane),
        .top       (dec_top),
        .timer_hit (dec_timer),
        .base      (dec_base)
    );

    wc_collect #(.ADDR_W(ADDR_W)) u_coll (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .kind      (dec_kind),
        .lane      (dec_lane),
        .top       (dec_top),
        .timer_hit (dec_timer),
        .base      (dec_base),
        .wdata     (wr_data),
        .fire      (fire),
        .fire_addr (fire_addr),
        .fire_data (fire_data),
        .fire_size (fire_size),
        .mask_q    (coll_mask)
    );

    wc_commit #(.ADDR_W(ADDR_W)) u_cmt (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_addr (fire_addr),
        .fire_data (fire_data),
        .fire_size (fire_size),
        .valid_q   (cmt_valid),
        .addr_q    (cmt_addr),
        .data_q    (cmt_data),
        .size_q    (size_q)
    );

    assign cmt_size = size_q;
endmodule

// File: rtl/wc_chk.sv
`timescale 1ns/1ps
module wc_chk
    import wc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              cmt_valid,
    input logic [ADDR_W-1:0] cmt_addr,
    input logic [WIDE_W-1:0] cmt_data,
    input logic [1:0]        cmt_size,
    input logic [LANES-1:0]  coll_mask
);
    localparam logic [ADDR_W-1:0] TIMER_P0 = ADDR_W'(TIMER_OFF);

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |-> $past(wr_en));

    // R12
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |-> (cmt_size != 2'd3));

    // R2
    oword_align_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_size == 2'd2) |-> (cmt_addr[3:0] == 4'h0));

    // R3
    qword_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_size == 2'd1) |-> (cmt_addr[2:0] == 3'h0 && cmt_data[127:64] == '0));

    // R10
    dword_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_size == 2'd0) |-> (cmt_data[127:32] == '0 && cmt_addr[1:0] == 2'b00));

    // R9
    timer_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == TIMER_P0) |=> (coll_mask == '0));

    // R11
    empty_after_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_size != 2'd0) |-> (coll_mask == '0));
endmodule

bind wide_write_collector wc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmt_valid (cmt_valid),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .cmt_size  (cmt_size),
    .coll_mask (coll_mask)
);

// File: tb/tb_wide_write_collector.sv
`timescale 1ns/1ps
module tb_wide_write_collector;
    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [19:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          cmt_valid;
    logic [19:0]   cmt_addr;
    logic [127:0]  cmt_data;
    logic [1:0]    cmt_size;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wide_write_collector dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_data(cmt_data), .cmt_size(cmt_size)
    );

    task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic ef,
                      input logic [19:0] ea, input logic [127:0] ed, input logic [1:0] es,
                      input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        checks++;
        if (ef) begin
            if (!(cmt_valid === 1'b1 && cmt_addr === ea && cmt_data === ed && cmt_size === es)) begin
                failures++;
                $display("FAIL %s wr %h: actual v=%b a=%h d=%h s=%0d expected v=1 a=%h d=%h s=%0d",
                         req, a, cmt_valid, cmt_addr, cmt_data, cmt_size, ea, ed, es);
            end
        end else if (cmt_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s wr %h: actual v=%b d=%h expected v=0", req, a, cmt_valid, cmt_data);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wn(input logic [19:0] a, input logic [31:0] d, input string req);
        wr(a, d, 1'b0, '0, '0, 2'd0, req);
    endtask

    task automatic idle_chk(input string req);
        @(posedge clk); #1;
        checks++;
        if (cmt_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s idle: actual v=%b expected v=0", req, cmt_valid);
        end
    endtask

    task automatic t_reset;
        checks++;
        if (cmt_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual v=%b expected v=0", cmt_valid);
        end
        wr(20'h0083C, 32'h1111_0003, 1'b1, 20'h00830, {32'h1111_0003, 96'h0}, 2'd2, "R1");
    endtask

    task automatic t_wide;
        wn(20'h00018, 32'hA000_0002, "R2");
        wn(20'h00010, 32'hA000_0000, "R2");
        wn(20'h0001C, 32'hA000_0003, "R2");
        wr(20'h00014, 32'hA000_0001, 1'b1, 20'h00010,
           {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000}, 2'd2, "R2 R12");
        idle_chk("R11");
    endtask

    task automatic t_mem;
        wn(20'h8001C, 32'hB000_0001, "R3");
        wr(20'h80018, 32'hB000_0000, 1'b1, 20'h80018,
           {64'h0, 32'hB000_0001, 32'hB000_0000}, 2'd1, "R3");
    endtask

    task automatic t_restart;
        wn(20'h00020, 32'hC000_0000, "R4");
        wn(20'h00024, 32'hC000_0001, "R4");
        wn(20'h00030, 32'hD000_0000, "R4");
        wn(20'h00034, 32'hD000_0001, "R4");
        wn(20'h00038, 32'hD000_0002, "R4");
        wr(20'h0003C, 32'hD000_0003, 1'b1, 20'h00030,
           {32'hD000_0003, 32'hD000_0002, 32'hD000_0001, 32'hD000_0000}, 2'd2, "R4");
        wn(20'h00028, 32'hC000_0002, "R4");
        wn(20'h0002C, 32'hC000_0003, "R4");
    endtask

    // collector holds lanes 2,3 of 0x020 on entry
    task automatic t_timer0;
        wr(20'h00420, 32'h7000_0000, 1'b1, 20'h00420, {96'h0, 32'h7000_0000}, 2'd0, "R9 R10");
        wn(20'h00020, 32'hE000_0000, "R9");
        wn(20'h00024, 32'hE000_0001, "R9");
        wn(20'h00028, 32'hE000_0002, "R9");
        wr(20'h0002C, 32'hE000_0003, 1'b1, 20'h00020,
           {32'hE000_0003, 32'hE000_0002, 32'hE000_0001, 32'hE000_0000}, 2'd2, "R9");
    endtask

    task automatic t_timer_page;
        wn(20'h00040, 32'hF000_0000, "R9");
        wn(20'h00044, 32'hF000_0001, "R9");
        wn(20'h00048, 32'hF000_0002, "R9");
        wr(20'h02420, 32'h7000_0001, 1'b1, 20'h02420, {96'h0, 32'h7000_0001}, 2'd0, "R9 R8");
        wr(20'h0004C, 32'hF000_0003, 1'b1, 20'h00040,
           {32'hF000_0003, 32'hF000_0002, 32'hF000_0001, 32'hF000_0000}, 2'd2, "R9");
    endtask

    task automatic t_desc_full;
        wn(20'h06830, 32'h9000_0000, "R5");
        wn(20'h06834, 32'h9000_0001, "R5");
        wn(20'h06838, 32'h9000_0002, "R5");
        wr(20'h0683C, 32'h9000_0003, 1'b1, 20'h06830,
           {32'h9000_0003, 32'h9000_0002, 32'h9000_0001, 32'h9000_0000}, 2'd2, "R5 R8");
        wr(20'h0683C, 32'h9000_0004, 1'b1, 20'h06830, {32'h9000_0004, 96'h0}, 2'd2, "R11");
    endtask

    task automatic t_desc_zero;
        wn(20'h0AA10, 32'h8000_0000, "R6");
        wn(20'h0AA14, 32'h8000_0001, "R6");
        wr(20'h0AA1C, 32'h8000_0003, 1'b1, 20'h0AA10, {32'h8000_0003, 96'h0}, 2'd2, "R6 R8");
    endtask

    task automatic t_desc_drop;
        wn(20'h00050, 32'h6000_0000, "R7");
        wn(20'h00054, 32'h6000_0001, "R7");
        wn(20'h04830, 32'h5000_0000, "R7");
        wn(20'h00058, 32'h6000_0002, "R7");
        wr(20'h0005C, 32'h6000_0003, 1'b1, 20'h00050,
           {32'h6000_0003, 32'h6000_0002, 32'h6000_0001, 32'h6000_0000}, 2'd2, "R7");
        wr(20'h0483C, 32'h5000_0003, 1'b1, 20'h04830, {32'h5000_0003, 96'h0}, 2'd2, "R7");
    endtask

    task automatic t_desc_foreign;
        wn(20'h00060, 32'h4000_0000, "R5");
        wn(20'h00064, 32'h4000_0001, "R5");
        wr(20'h04A1C, 32'h3000_0003, 1'b1, 20'h04A10, {32'h3000_0003, 96'h0}, 2'd2, "R5");
        wn(20'h00068, 32'h4000_0002, "R11");
        wn(20'h0006C, 32'h4000_0003, "R11");
    endtask

    task automatic t_single;
        wr(20'h01000, 32'h2000_0000, 1'b1, 20'h01000, {96'h0, 32'h2000_0000}, 2'd0, "R10");
        wr(20'h00400, 32'h2000_0001, 1'b1, 20'h00400, {96'h0, 32'h2000_0001}, 2'd0, "R10");
        idle_chk("R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_wide();
        t_mem();
        t_restart();
        t_timer0();
        t_timer_page();
        t_desc_full();
        t_desc_zero();
        t_desc_drop();
        t_desc_foreign();
        t_single();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule